// File: doc/BRIEF.md
# Three-State Snooping Coherence Line Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. It holds a small set of lines, one data word each, selected by a line index. Each line is Invalid, Shared or Modified. Processor reads and writes are served locally when the line's state allows it. Otherwise the block raises a bus request that carries the command the protocol calls for, and it holds the processor stalled until the arbiter grants the bus.

Bus traffic from other caches reaches the block on a snoop port. A snooped read of a Modified line pushes the dirty word out on the flush port and downgrades the line to Shared. A snooped exclusive read or an upgrade invalidates the line. If that line was Modified, its data is flushed first.

A snoop is applied in the same cycle it arrives, and a pending processor request is then judged against the state the snoop leaves behind. Bus command codes: 0 idle, 1 read (shared fetch), 2 exclusive read (fetch for ownership), 3 upgrade (ownership without data).

Top module: `msi_line_ctrl`

## Requirements
- R1: A processor read of an Invalid line raises busReq with busCmd 1 and stalls. In the cycle busGrant is high the read completes, cpuRdata equals memData, and the line becomes Shared holding that word.
- R2: A processor read of a Shared or Modified line completes in the same cycle with the stored word and no bus request. A snooped read (snpCmd 1) of a Shared line flushes nothing and leaves the line Shared.
- R3: A processor write to an Invalid line raises busReq with busCmd 2. On grant the write completes and the line becomes Modified holding cpuWdata.
- R4: A processor write to a Shared line raises busReq with busCmd 3. On grant the line becomes Modified holding cpuWdata.
- R5: A processor write to a Modified line completes in the same cycle with no bus request and stores cpuWdata. The line stays Modified.
- R6: A snooped exclusive read (snpCmd 2) or upgrade (snpCmd 3) of a Shared or Modified line leaves it Invalid.
- R7: A snooped read of a Modified line asserts flushValid in that cycle, with flushIdx equal to snpIdx and flushData equal to the stored word. The line becomes Shared.
- R8: A snooped exclusive read or upgrade of a Modified line also flushes the stored word in that cycle before the line is invalidated.
- R9: While a request needs the bus and busGrant is low, cpuBusy is 1, cpuDone is 0, busReq and busCmd hold steady, and snoops to other lines are still serviced.
- R10: When a snoop and a processor request address the same line in one cycle, the snoop takes effect first and the request sees the resulting state.
- R11: After reset every line is Invalid.
- R12: A snoop changes only the line it addresses. Lines at other indices keep their state and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present; held until cpuDone |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuIdx | input | IDX_W | Line index of the request |
| cpuWdata | input | DATA_W | Write data |
| cpuDone | output | 1 | Request completes this cycle |
| cpuBusy | output | 1 | Request stalled waiting for the bus |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone on a read |
| busReq | output | 1 | Bus needed for the current request |
| busCmd | output | 2 | Command to issue: 0 idle, 1 read, 2 exclusive read, 3 upgrade |
| busIdx | output | IDX_W | Line index of the bus command |
| busGrant | input | 1 | Arbiter grant for this cycle |
| memData | input | DATA_W | Fill word returned in the grant cycle |
| snpValid | input | 1 | Snooped transaction from another cache |
| snpCmd | input | 2 | Snooped command, same encoding as busCmd |
| snpIdx | input | IDX_W | Line index of the snooped transaction |
| flushValid | output | 1 | Dirty word is being written back this cycle |
| flushIdx | output | IDX_W | Line index of the flushed word |
| flushData | output | DATA_W | Flushed word |

## Verification
Two functions can fall in one cycle: a snoop and a local processor request to the same line. The bench sets a line to Shared or Modified. It then presents a read or a write in the same cycle as a snooped read or exclusive read, with the grant held low. It checks the flush outputs against the pre-snoop data. It checks cpuDone and busCmd against the state the snoop leaves behind. Each line's final state is then read back through non-granted read and write probes, and the results are compared with a state model computed in the bench.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } lineSt_t;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_UPGR = 2'd3
  } busCmd_t;

  // strobes from control to datapath; all writes land at the request index
  typedef struct packed {
    logic wrEn;      // update the addressed word this cycle
    logic fromCpu;   // 1: take cpuWdata, 0: take memData
    logic bypass;    // read data comes from the fill, not the array
  } dpStrobe_t;

  function automatic lineSt_t snoopNext(lineSt_t cur, logic [1:0] cmd);
    lineSt_t res;
    res = cur;
    case (cmd)
      CMD_RD:            if (cur == LN_MOD) res = LN_SHR;
      CMD_RDX, CMD_UPGR: res = LN_INV;
      default:           res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuValid,
  input  logic             cpuWrite,
  input  logic [IDX_W-1:0] cpuIdx,
  input  logic             busGrant,
  input  logic             snpValid,
  input  logic [1:0]       snpCmd,
  input  logic [IDX_W-1:0] snpIdx,
  output logic             cpuDone,
  output logic             cpuBusy,
  output logic             busReq,
  output logic [1:0]       busCmd,
  output logic [IDX_W-1:0] busIdx,
  output logic             flushValid,
  output logic [IDX_W-1:0] flushIdx,
  output dpStrobe_t        strb
);

  lineSt_t curSt  [NUM_LINES];
  lineSt_t postSt [NUM_LINES];
  lineSt_t cpuSt;
  busCmd_t needCmd;
  logic    snpActive;

  assign snpActive = snpValid && (snpCmd != CMD_IDLE);

  // per-line state register and its snoop-then-processor update
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    lineSt_t stQ;
    lineSt_t stNxt;
    logic    snpHere;
    logic    cpuHere;

    assign snpHere   = snpActive && (snpIdx == IDX_W'(i));
    assign cpuHere   = cpuDone && (cpuIdx == IDX_W'(i));
    assign curSt[i]  = stQ;
    assign postSt[i] = snpHere ? snoopNext(stQ, snpCmd) : stQ;

    always_comb begin
      stNxt = postSt[i];
      if (cpuHere) begin
        if (cpuWrite)                stNxt = LN_MOD;
        else if (stNxt == LN_INV)    stNxt = LN_SHR;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) stQ <= LN_INV;
      else       stQ <= stNxt;
    end
  end

  // a snoop on the requested line is resolved before the request is judged
  assign cpuSt = postSt[cpuIdx];

  always_comb begin
    needCmd = CMD_IDLE;
    if (cpuValid) begin
      if (cpuWrite) begin
        case (cpuSt)
          LN_INV:  needCmd = CMD_RDX;
          LN_SHR:  needCmd = CMD_UPGR;
          default: needCmd = CMD_IDLE;
        endcase
      end else if (cpuSt == LN_INV) begin
        needCmd = CMD_RD;
      end
    end
  end

  assign busReq  = (needCmd != CMD_IDLE);
  assign busCmd  = needCmd;
  assign busIdx  = cpuIdx;
  assign cpuDone = cpuValid && (!busReq || busGrant);
  assign cpuBusy = cpuValid && !cpuDone;

  assign flushValid = snpActive && (curSt[snpIdx] == LN_MOD);
  assign flushIdx   = snpIdx;

  always_comb begin
    strb.bypass  = (cpuSt == LN_INV);
    strb.fromCpu = cpuWrite;
    strb.wrEn    = cpuDone && (cpuWrite || cpuSt == LN_INV);
  end

endmodule

// File: rtl/msi_data.sv
module msi_data
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [IDX_W-1:0]  snpIdx,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] flushData
);

  logic [DATA_W-1:0] word [NUM_LINES];
  logic [DATA_W-1:0] wrVal;

  assign wrVal = strb.fromCpu ? cpuWdata : memData;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_word
    logic [DATA_W-1:0] wordQ;
    assign word[i] = wordQ;
    always_ff @(posedge clk) begin
      if (!rstN)                                  wordQ <= '0;
      else if (strb.wrEn && cpuIdx == IDX_W'(i))  wordQ <= wrVal;
    end
  end

  assign cpuRdata  = strb.bypass ? memData : word[cpuIdx];
  assign flushData = word[snpIdx];

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter  int NUM_LINES = 4,
  parameter  int DATA_W    = 32,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic              cpuBusy,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [IDX_W-1:0]  busIdx,
  input  logic              busGrant,
  input  logic [DATA_W-1:0] memData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [IDX_W-1:0]  snpIdx,
  output logic              flushValid,
  output logic [IDX_W-1:0]  flushIdx,
  output logic [DATA_W-1:0] flushData
);

  dpStrobe_t strb;

  msi_ctrl #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuIdx(cpuIdx),
    .busGrant(busGrant),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpIdx(snpIdx),
    .cpuDone(cpuDone), .cpuBusy(cpuBusy),
    .busReq(busReq), .busCmd(busCmd), .busIdx(busIdx),
    .flushValid(flushValid), .flushIdx(flushIdx),
    .strb(strb)
  );

  msi_data #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuIdx(cpuIdx), .snpIdx(snpIdx),
    .cpuWdata(cpuWdata), .memData(memData),
    .cpuRdata(cpuRdata), .flushData(flushData)
  );

endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuValid,
  input logic             cpuWrite,
  input logic [IDX_W-1:0] cpuIdx,
  input logic             cpuDone,
  input logic             cpuBusy,
  input logic             busReq,
  input logic [1:0]       busCmd,
  input logic             busGrant,
  input logic             snpValid,
  input logic [1:0]       snpCmd,
  input logic [IDX_W-1:0] snpIdx,
  input logic             flushValid,
  input logic [IDX_W-1:0] flushIdx
);

  // stall only while the bus is wanted and not yet granted
  p_stall_wants_bus_r9: assert property (@(posedge clk) disable iff (!rstN)
    cpuBusy |-> (busReq && !busGrant && !cpuDone));

  // a stalled request keeps presenting the same command
  p_stall_cmd_steady_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuBusy) && cpuValid && cpuIdx == $past(cpuIdx) && cpuWrite == $past(cpuWrite)
     && !$past(snpValid) && !snpValid) |-> (busReq && busCmd == $past(busCmd)));

  // a granted bus request always completes the processor request
  p_grant_completes_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && busReq && busGrant) |-> cpuDone);

  // reads never ask for ownership
  p_read_fetch_shared_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !cpuWrite && busReq) |-> busCmd == 2'd1);

  // a flush is always a reply to a snoop of the same line
  p_flush_on_snoop_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> (snpValid && snpCmd != 2'd0 && flushIdx == snpIdx));

  // an invalidated line has nothing left to flush on the next snoop
  p_no_flush_after_inval_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(snpValid && snpCmd[1]) && !$past(busGrant) && snpValid
     && snpIdx == $past(snpIdx)) |-> !flushValid);

endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuIdx(cpuIdx),
  .cpuDone(cpuDone), .cpuBusy(cpuBusy),
  .busReq(busReq), .busCmd(busCmd), .busGrant(busGrant),
  .snpValid(snpValid), .snpCmd(snpCmd), .snpIdx(snpIdx),
  .flushValid(flushValid), .flushIdx(flushIdx)
);

// File: tb/msi_line_ctrl_tb.sv
module msi_line_ctrl_tb;

  localparam int NL = 4;
  localparam int DW = 32;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cpuValid, cpuWrite, busGrant, snpValid;
  logic [IW-1:0] cpuIdx, snpIdx;
  logic [DW-1:0] cpuWdata, memData;
  logic [1:0]    snpCmd;
  logic          cpuDone, cpuBusy, busReq, flushValid;
  logic [1:0]    busCmd;
  logic [IW-1:0] busIdx, flushIdx;
  logic [DW-1:0] cpuRdata, flushData;

  int nChk = 0;
  int nErr = 0;
  int mSt  [NL];
  logic [DW-1:0] mDat [NL];

  always #5 clk = ~clk;

  msi_line_ctrl #(.NUM_LINES(NL), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuIdx(cpuIdx), .cpuWdata(cpuWdata),
    .cpuDone(cpuDone), .cpuBusy(cpuBusy), .cpuRdata(cpuRdata),
    .busReq(busReq), .busCmd(busCmd), .busIdx(busIdx),
    .busGrant(busGrant), .memData(memData),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpIdx(snpIdx),
    .flushValid(flushValid), .flushIdx(flushIdx), .flushData(flushData)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpuValid = 0; cpuWrite = 0; cpuIdx = '0; cpuWdata = '0;
    busGrant = 0; memData = '0; snpValid = 0; snpCmd = 0; snpIdx = '0;
  endtask

  // from a negedge: let the edge happen, return at the next negedge with inputs idle
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic int snpNext(int s, int cmd);
    if (cmd == 1) return (s == 2) ? 1 : s;
    if (cmd >= 2) return 0;
    return s;
  endfunction

  function automatic int wrCmd(int s);
    return (s == 0) ? 2 : (s == 1) ? 3 : 0;
  endfunction

  task automatic modelSnoop(int idx, int cmd);
    mSt[idx] = snpNext(mSt[idx], cmd);
  endtask

  // read and write probes without grant reveal the state and leave it unchanged
  task automatic probe(int idx, string tag);
    cpuValid = 1; cpuWrite = 0; cpuIdx = IW'(idx); busGrant = 0;
    #2;
    chk({tag, " probe read busReq"}, DW'(busReq), DW'(mSt[idx] == 0));
    if (mSt[idx] != 0) chk({tag, " probe read data"}, cpuRdata, mDat[idx]);
    step();
    cpuValid = 1; cpuWrite = 1; cpuIdx = IW'(idx); cpuWdata = mDat[idx]; busGrant = 0;
    #2;
    chk({tag, " probe write busCmd"}, DW'(busCmd), DW'(wrCmd(mSt[idx])));
    chk({tag, " probe write done"}, DW'(cpuDone), DW'(mSt[idx] == 2));
    step();
  endtask

  task automatic probeAll(string tag);
    for (int i = 0; i < NL; i++) probe(i, tag);
  endtask

  task automatic setState(int idx, int s, logic [DW-1:0] d);
    snpValid = 1; snpCmd = 2; snpIdx = IW'(idx);
    step();
    mSt[idx] = 0;
    if (s == 1) begin
      cpuValid = 1; cpuWrite = 0; cpuIdx = IW'(idx); busGrant = 1; memData = d;
      step();
      mSt[idx] = 1; mDat[idx] = d;
    end else if (s == 2) begin
      cpuValid = 1; cpuWrite = 1; cpuIdx = IW'(idx); busGrant = 1; cpuWdata = d;
      step();
      mSt[idx] = 2; mDat[idx] = d;
    end
  endtask

  // one event against a line in a known state
  task automatic runCase(int idx, int s, int ev);
    logic [DW-1:0] d0, d1;
    int oth, sIdx, sCmd, fs;
    d0  = 32'hA000_0000 | DW'(idx * 256 + s * 16 + ev);
    d1  = 32'h5B00_0000 | DW'(idx * 256 + s * 16 + ev);
    oth = (idx + 1) % NL;
    setState(idx, s, d0);
    case (ev)
      0: begin
        cpuValid = 1; cpuWrite = 0; cpuIdx = IW'(idx); busGrant = 1; memData = d1;
        #2;
        chk(s == 0 ? "R1 fill read busReq" : "R2 hit read busReq", DW'(busReq), DW'(s == 0));
        chk(s == 0 ? "R1 fill read busCmd" : "R2 hit read busCmd", DW'(busCmd), DW'(s == 0 ? 1 : 0));
        chk("R1 read done", DW'(cpuDone), 1);
        chk(s == 0 ? "R1 fill read data" : "R2 hit read data", cpuRdata, s == 0 ? d1 : d0);
        step();
        if (s == 0) begin mSt[idx] = 1; mDat[idx] = d1; end
      end
      1: begin
        cpuValid = 1; cpuWrite = 1; cpuIdx = IW'(idx); busGrant = 1; cpuWdata = d1;
        #2;
        chk(s == 0 ? "R3 write busCmd" : s == 1 ? "R4 upgrade busCmd" : "R5 hit write busCmd",
            DW'(busCmd), DW'(wrCmd(s)));
        chk("R5 write done", DW'(cpuDone), 1);
        step();
        mSt[idx] = 2; mDat[idx] = d1;
      end
      default: begin
        sCmd = (ev == 5) ? 2 : ev - 1;
        sIdx = (ev == 5) ? oth : idx;
        fs   = mSt[sIdx];
        snpValid = 1; snpCmd = 2'(sCmd); snpIdx = IW'(sIdx);
        #2;
        chk(sCmd == 1 ? "R7 snoop read flushValid" : "R8 snoop excl flushValid",
            DW'(flushValid), DW'(fs == 2));
        if (fs == 2) begin
          chk(sCmd == 1 ? "R7 flushData" : "R8 flushData", flushData, mDat[sIdx]);
          chk("R7 flushIdx", DW'(flushIdx), DW'(sIdx));
        end
        step();
        modelSnoop(sIdx, sCmd);
      end
    endcase
    probeAll(ev >= 2 ? "R6 R12 state after snoop" : "R1 R3 R4 state after request");
  endtask

  // stall without grant, with a snoop to another line in the middle
  task automatic runStall(int idx, int s, int wr);
    logic [DW-1:0] d1;
    int oth, fs, exCmd;
    d1  = 32'hC300_0000 | DW'(idx * 16 + s * 4 + wr);
    oth = (idx + 2) % NL;
    setState(oth, 2, 32'hD00D_0000 | DW'(idx));
    setState(idx, s, 32'h1111_0000 | DW'(idx));
    exCmd = wr ? wrCmd(s) : 1;
    for (int c = 0; c < 3; c++) begin
      cpuValid = 1; cpuWrite = wr[0]; cpuIdx = IW'(idx); cpuWdata = d1; busGrant = 0;
      if (c == 1) begin snpValid = 1; snpCmd = 1; snpIdx = IW'(oth); end
      #2;
      chk("R9 stall busy", DW'(cpuBusy), 1);
      chk("R9 stall done", DW'(cpuDone), 0);
      chk("R9 stall busCmd", DW'(busCmd), DW'(exCmd));
      chk("R9 stall busIdx", DW'(busIdx), DW'(idx));
      if (c == 1) begin
        fs = mSt[oth];
        chk("R9 snoop serviced during stall", DW'(flushValid), DW'(fs == 2));
      end
      step();
      if (c == 1) modelSnoop(oth, 1);
    end
    cpuValid = 1; cpuWrite = wr[0]; cpuIdx = IW'(idx); cpuWdata = d1;
    busGrant = 1; memData = d1;
    #2;
    chk("R9 granted done", DW'(cpuDone), 1);
    chk("R9 granted busy", DW'(cpuBusy), 0);
    step();
    mSt[idx] = wr ? 2 : (s == 0 ? 1 : s);
    if (wr || s == 0) mDat[idx] = d1;
    probeAll("R9 state after stall");
  endtask

  // snoop and processor request on the same line in one cycle, no grant
  task automatic runCollide(int s, int sCmd, int wr);
    logic [DW-1:0] d0, d1;
    int post, hit;
    d0 = 32'hE000_0000 | DW'(s * 16 + sCmd * 4 + wr);
    d1 = 32'h7700_0000 | DW'(s * 16 + sCmd * 4 + wr);
    setState(1, s, d0);
    post = snpNext(s, sCmd);
    hit  = wr ? (post == 2) : (post != 0);
    cpuValid = 1; cpuWrite = wr[0]; cpuIdx = 1; cpuWdata = d1; busGrant = 0;
    snpValid = 1; snpCmd = 2'(sCmd); snpIdx = 1;
    #2;
    chk("R10 collide flushValid", DW'(flushValid), DW'(s == 2));
    if (s == 2) chk("R10 collide flushData", flushData, d0);
    chk("R10 collide done", DW'(cpuDone), DW'(hit));
    chk("R10 collide busCmd", DW'(busCmd), DW'(hit ? 0 : (wr ? wrCmd(post) : 1)));
    if (hit && !wr) chk("R10 collide read data", cpuRdata, d0);
    step();
    mSt[1] = post;
    if (hit && wr) begin mSt[1] = 2; mDat[1] = d1; end
    probeAll("R10 state after collision");
  endtask

  initial begin
    idle();
    rstN = 0;
    for (int i = 0; i < NL; i++) begin mSt[i] = 0; mDat[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    #2;
    chk("R11 reset busReq", DW'(busReq), 0);
    chk("R11 reset flushValid", DW'(flushValid), 0);
    @(negedge clk);
    snpValid = 1; snpCmd = 1; snpIdx = 0;
    #2;
    chk("R11 reset no dirty line", DW'(flushValid), 0);
    step();
    probeAll("R11 reset state");

    for (int idx = 0; idx < NL; idx++)
      for (int s = 0; s < 3; s++)
        for (int ev = 0; ev < 6; ev++)
          runCase(idx, s, ev);

    for (int idx = 0; idx < NL; idx++)
      for (int s = 0; s < 2; s++)
        for (int wr = 0; wr < 2; wr++)
          if (!(s == 1 && wr == 0)) runStall(idx, s, wr);

    for (int s = 1; s < 3; s++)
      for (int sCmd = 1; sCmd < 3; sCmd++)
        for (int wr = 0; wr < 2; wr++)
          runCollide(s, sCmd, wr);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    #1_000_000;
    nChk++;
    nErr++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

endmodule